// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Drive Sequencer

This block sequences the enables of the high-side and low-side switches of one synchronous buck phase. A controller supplies a PWM level that analog comparators have already reduced to three codes: high, low and mid band. The sequencer turns one switch off before it turns the other on. The gap between them is not fixed. It waits for a sense flag that reports the outgoing gate as discharged, then adds a short programmable delay. If that flag never arrives, a timeout lets the sequence continue.

When the PWM level moves from low into the mid band, the block enters diode emulation. The low-side enable stays on for a programmable minimum time. Once both that time and a settle time have passed, the block watches the zero-crossing flag and drops the low-side enable when the flag rises, so the low-side switch never sinks current. With no further PWM activity both enables stay low. The enables are forced low whenever the supply-good flag or the enable input is low. Gate control restarts from the PWM level once both flags are valid again.

Top module: `gdrv_seq`

## Requirements
- R1: When PWM rises, the low-side enable drops first. The high-side enable rises PD_CYC+1 clock cycles after the low-side discharged flag is first seen high.
- R2: When PWM falls, the high-side enable drops first. The low-side enable rises PD_CYC+1 clock cycles after the high-side discharged flag is first seen high.
- R3: The high-side and low-side enables are never high in the same cycle.
- R4: If the discharged flag of the outgoing gate stays low, the pending gate enable still rises TMO_CYC+PD_CYC cycles after the outgoing enable dropped.
- R5: The PWM code is 2'b01 for high, 2'b00 for low, and 2'b10 or 2'b11 for the mid band. The code passes through a two-flop synchronizer, so an enable first reacts three clock edges after a PWM change.
- R6: In diode emulation the zero-crossing flag is ignored until both MINON_CYC and SETTLE_CYC have elapsed. With the flag held high, the low-side enable falls max(MINON_CYC,SETTLE_CYC)+4 edges after the PWM change to mid.
- R7: In diode emulation the low-side enable stays on while the zero-crossing flag is low, and falls on the first clock edge after the flag is seen high once the hold time has passed.
- R8: While PWM stays in the mid band after diode emulation has ended, or after power-up, both enables stay low.
- R9: A PWM change to high during diode emulation drops the low-side enable and then follows the R1 handshake. A change back to low keeps the low-side enable on without a gap.
- R10: When drv_en or pwr_good is low, both enables are low in the same cycle. After both return high, the sequence restarts from the current PWM code; with PWM high and the low side discharged, the high-side enable rises PD_CYC+3 edges later.
- R11: Reset holds both enables low and puts the sequencer in an idle state that waits for drv_en and pwr_good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_lvl | input | 2 | Comparator-decoded PWM level (01 high, 00 low, 1x mid) |
| lg_dis | input | 1 | Low-side gate sensed discharged |
| ug_dis | input | 1 | High-side gate-to-phase sensed discharged |
| zc_det | input | 1 | Inductor current at zero or negative |
| drv_en | input | 1 | Driver enable |
| pwr_good | input | 1 | Supply above its valid threshold |
| ug_on | output | 1 | High-side gate enable |
| lg_on | output | 1 | Low-side gate enable |

## Verification
The assertions assume that the sense flags and the zero-crossing flag are already synchronous to clk. They also assume that a discharged flag is high only while its gate enable is off, because the sequencer itself does not filter these flags. The random stimulus keeps to these assumptions. A small gate model in the bench raises each discharged flag only after the matching enable has been low for two samples, while the PWM code, zero-crossing flag and enables change freely. The directed cases then hold a discharged flag low on purpose to reach the timeout path.

// File: rtl/gdrv_pkg.sv
// Shared types for the gate drive sequencer: the decoded PWM level and the
// sequencer state encoding. Assumes a two-bit comparator code at the input.
package gdrv_pkg;

    typedef enum logic [1:0] {
        PWM_LOW  = 2'b00,
        PWM_HIGH = 2'b01,
        PWM_MID  = 2'b10
    } pwm_lvl_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OFF,
        ST_WAIT_LG,
        ST_DLY_HI,
        ST_HIGH,
        ST_WAIT_UG,
        ST_DLY_LO,
        ST_LOW,
        ST_DE,
        ST_DE_OFF
    } seq_st_e;

    // Map the raw comparator code to a level; both codes with bit 1 set mean mid band.
    function automatic pwm_lvl_e pwm_decode(input logic [1:0] code);
        case (code)
            2'b01:   return PWM_HIGH;
            2'b00:   return PWM_LOW;
            default: return PWM_MID;
        endcase
    endfunction

    // Larger of two non-negative integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gdrv_sync.sv
// Multi-stage synchronizer for a bus of level signals.
// Assumes each bit is a slow level that needs no coherence across bits
// beyond what the downstream decoder tolerates for one cycle.
module gdrv_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous input in the first flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                // Pass the value down the chain to settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gdrv_timer.sv
// Saturating up-counter measuring cycles spent in the current sequencer state.
// Assumes clr is pulsed on the edge that enters a new state.
module gdrv_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_TOP = '1;

    // Restart at zero on clear, otherwise count up and hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (clr)             cnt <= '0;
        else if (cnt != CNT_TOP)  cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/gdrv_fsm.sv
// Break-before-make sequencer with diode emulation.
// Assumes lvl is already synchronized, the sense flags are synchronous to clk,
// and run_ok combines enable and supply-good. Delay parameters must be >= 1.
module gdrv_fsm
    import gdrv_pkg::*;
#(
    parameter int PD_CYC     = 4,
    parameter int MINON_CYC  = 44,
    parameter int SETTLE_CYC = 41,
    parameter int TMO_CYC    = 64,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pwm_lvl_e         lvl,
    input  logic             lg_dis,
    input  logic             ug_dis,
    input  logic             zc_det,
    input  logic             run_ok,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             ug_req,
    output logic             lg_req
);

    localparam int HOLD_CYC = imax(MINON_CYC, SETTLE_CYC);
    localparam logic [CNT_W-1:0] PD_LAST  = CNT_W'(PD_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_V   = CNT_W'(HOLD_CYC);

    seq_st_e st_q, st_n;
    logic    tmo_hit, pd_done, de_release;

    assign tmo_hit    = (cnt == TMO_LAST);
    assign pd_done    = (cnt == PD_LAST);
    assign de_release = zc_det && (cnt >= HOLD_V);

    // Next-state selection: disable has priority, then PWM level, then handshakes.
    always_comb begin
        st_n = st_q;
        if (!run_ok) begin
            st_n = ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE:    st_n = ST_OFF;
                ST_OFF: begin
                    if (lvl == PWM_HIGH)     st_n = ST_WAIT_LG;
                    else if (lvl == PWM_LOW) st_n = ST_WAIT_UG;
                end
                ST_WAIT_LG: begin
                    if (lvl == PWM_LOW)             st_n = ST_WAIT_UG;
                    else if (lvl == PWM_MID)        st_n = ST_OFF;
                    else if (lg_dis || tmo_hit)     st_n = ST_DLY_HI;
                end
                ST_DLY_HI: begin
                    if (lvl == PWM_LOW)        st_n = ST_WAIT_UG;
                    else if (lvl == PWM_MID)   st_n = ST_OFF;
                    else if (pd_done)          st_n = ST_HIGH;
                end
                ST_HIGH: begin
                    if (lvl == PWM_LOW)        st_n = ST_WAIT_UG;
                    else if (lvl == PWM_MID)   st_n = ST_OFF;
                end
                ST_WAIT_UG: begin
                    if (lvl == PWM_HIGH)            st_n = ST_WAIT_LG;
                    else if (lvl == PWM_MID)        st_n = ST_OFF;
                    else if (ug_dis || tmo_hit)     st_n = ST_DLY_LO;
                end
                ST_DLY_LO: begin
                    if (lvl == PWM_HIGH)       st_n = ST_WAIT_LG;
                    else if (lvl == PWM_MID)   st_n = ST_OFF;
                    else if (pd_done)          st_n = ST_LOW;
                end
                ST_LOW: begin
                    if (lvl == PWM_HIGH)       st_n = ST_WAIT_LG;
                    else if (lvl == PWM_MID)   st_n = ST_DE;
                end
                ST_DE: begin
                    if (lvl == PWM_HIGH)       st_n = ST_WAIT_LG;
                    else if (lvl == PWM_LOW)   st_n = ST_LOW;
                    else if (de_release)       st_n = ST_DE_OFF;
                end
                ST_DE_OFF: begin
                    if (lvl == PWM_HIGH)       st_n = ST_WAIT_LG;
                    else if (lvl == PWM_LOW)   st_n = ST_WAIT_UG;
                end
                default:    st_n = ST_IDLE;
            endcase
        end
    end

    // State register, idle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // Restart the state timer whenever the state changes.
    assign cnt_clr = (st_n != st_q);

    // Gate requests decoded from the current state.
    assign ug_req = (st_q == ST_HIGH);
    assign lg_req = (st_q == ST_LOW) || (st_q == ST_DE);

    AST_UG_AFTER_LG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ug_req) |-> (!$past(lg_req) && !$past(lg_req, 2)));   // R1
    AST_LG_AFTER_UG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lg_req) |-> (!$past(ug_req) && !$past(ug_req, 2)));   // R2
    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_LG || st_q == ST_WAIT_UG) |-> (cnt <= TMO_LAST)); // R4
    AST_DE_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DE_OFF && $past(st_q) == ST_DE) |-> ($past(cnt) >= HOLD_V)); // R6
    AST_DE_ZC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DE_OFF && $past(st_q) == ST_DE) |-> $past(zc_det)); // R7
    AST_MID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == PWM_MID && $past(lvl) == PWM_MID && !$past(lg_req) && !$past(ug_req))
        |-> (!lg_req && !ug_req));   // R8

endmodule

// File: rtl/gdrv_seq.sv
// Top of the adaptive dead-time gate drive sequencer for one buck phase.
// Assumes comparator outputs and sense flags are digital levels; only the
// PWM code is treated as asynchronous and synchronized here.
module gdrv_seq
    import gdrv_pkg::*;
#(
    parameter int PD_CYC     = 4,
    parameter int MINON_CYC  = 44,
    parameter int SETTLE_CYC = 41,
    parameter int TMO_CYC    = 64,
    parameter int SYNC_STG   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_lvl,
    input  logic       lg_dis,
    input  logic       ug_dis,
    input  logic       zc_det,
    input  logic       drv_en,
    input  logic       pwr_good,
    output logic       ug_on,
    output logic       lg_on
);

    localparam int MAX_DLY = imax(imax(PD_CYC, TMO_CYC), imax(MINON_CYC, SETTLE_CYC));
    localparam int CNT_W   = $clog2(MAX_DLY + 1) + 1;

    logic [1:0]       pwm_s;
    pwm_lvl_e         lvl;
    logic             run_ok;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt;
    logic             ug_req, lg_req;

    gdrv_sync #(.WIDTH(2), .STAGES(SYNC_STG), .RST_VAL(2'b00)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pwm_lvl),
        .q     (pwm_s)
    );

    assign lvl    = pwm_decode(pwm_s);
    assign run_ok = drv_en && pwr_good;

    gdrv_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    gdrv_fsm #(
        .PD_CYC     (PD_CYC),
        .MINON_CYC  (MINON_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .TMO_CYC    (TMO_CYC),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl),
        .lg_dis  (lg_dis),
        .ug_dis  (ug_dis),
        .zc_det  (zc_det),
        .run_ok  (run_ok),
        .cnt     (cnt),
        .cnt_clr (cnt_clr),
        .ug_req  (ug_req),
        .lg_req  (lg_req)
    );

    // Outputs are gated at once by enable and supply-good.
    assign ug_on = ug_req && run_ok;
    assign lg_on = lg_req && run_ok;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ug_on && lg_on));   // R3
    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_en && pwr_good) |-> (!ug_on && !lg_on));   // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (!ug_on && !lg_on));   // R11

endmodule

// File: tb/sim_gdrv_seq.sv
`timescale 1ns/1ps
module sim_gdrv_seq;

    localparam int PD  = 3;
    localparam int MON = 6;
    localparam int STL = 4;
    localparam int TMO = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwm = 2'b00;
    logic       d_lg = 1'b1, d_ug = 1'b1, m_lg = 1'b1, m_ug = 1'b1;
    logic       auto_sense = 1'b0;
    logic       zc = 1'b0, en = 1'b1, pg = 1'b1;
    logic       lg_dis, ug_dis, ug_on, lg_on;
    int         checks = 0, errors = 0;

    always #4 clk = ~clk;

    assign lg_dis = auto_sense ? m_lg : d_lg;
    assign ug_dis = auto_sense ? m_ug : d_ug;

    gdrv_seq #(.PD_CYC(PD), .MINON_CYC(MON), .SETTLE_CYC(STL), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm), .lg_dis(lg_dis), .ug_dis(ug_dis),
        .zc_det(zc), .drv_en(en), .pwr_good(pg), .ug_on(ug_on), .lg_on(lg_on)
    );

    // Expected latencies in clock edges, from the requirements.
    function automatic int exp_sync();      return 3;                 endfunction
    function automatic int exp_dead();      return PD + 1;            endfunction
    function automatic int exp_tmo();       return TMO + PD;          endfunction
    function automatic int exp_de();        return ((MON > STL) ? MON : STL) + 4; endfunction
    function automatic int exp_resume();    return PD + 3;            endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    // Count edges until the chosen enable (0 high-side, 1 low-side) equals val.
    task automatic wait_for(input int which, input logic val, input int maxc, output int n);
        n = maxc + 1;
        for (int i = 1; i <= maxc; i++) begin
            tick();
            if ((which == 0 ? ug_on : lg_on) == val) begin n = i; break; end
        end
    endtask

    task automatic go_low();
        int n;
        pwm = 2'b00;
        wait_for(0, 1'b0, 30, n); d_ug = 1'b1;
        wait_for(1, 1'b1, 30, n); d_lg = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] p);
        rst_n = 1'b0; pwm = p;
        repeat (4) tick();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, bad;
        logic [1:0] h0, h1, h2;
        logic lg_prev, ug_prev;
        void'($urandom(32'h5eed_0017));
        tick(); tick();
        chk("R11 reset ug", int'(ug_on), 0);
        chk("R11 reset lg", int'(lg_on), 0);
        rst_n = 1'b1;
        repeat (20) tick();
        chk("R2 bring-up lg", int'(lg_on), 1);
        d_lg = 1'b0;

        // R5 / R1: rising handshake
        pwm = 2'b01;
        wait_for(1, 1'b0, 20, n); chk("R5 sync latency", n, exp_sync());
        bad = 0;
        for (int i = 0; i < 5; i++) begin tick(); bad += int'(ug_on); end
        chk("R1 ug waits for lg sense", bad, 0);
        d_lg = 1'b1;
        wait_for(0, 1'b1, 20, n); chk("R1 dead time", n, exp_dead());
        d_ug = 1'b0;

        // R2: falling handshake
        pwm = 2'b00;
        wait_for(0, 1'b0, 20, n); chk("R2 ug off first", n, exp_sync());
        bad = 0;
        for (int i = 0; i < 4; i++) begin tick(); bad += int'(lg_on); end
        chk("R2 lg waits for ug sense", bad, 0);
        d_ug = 1'b1;
        wait_for(1, 1'b1, 20, n); chk("R2 dead time", n, exp_dead());
        d_lg = 1'b0;

        // R4: timeouts in both directions
        pwm = 2'b01;
        wait_for(1, 1'b0, 20, n);
        wait_for(0, 1'b1, 40, n); chk("R4 timeout rising", n, exp_tmo());
        d_ug = 1'b0; pwm = 2'b00;
        wait_for(0, 1'b0, 20, n);
        wait_for(1, 1'b1, 40, n); chk("R4 timeout falling", n, exp_tmo());
        d_ug = 1'b1; d_lg = 1'b0;

        // R6: minimum hold with zero-crossing already high
        zc = 1'b1; pwm = 2'b10;
        wait_for(1, 1'b0, 40, n); chk("R6 de hold", n, exp_de());
        zc = 1'b0; d_lg = 1'b1;

        // R8: quiet in mid band
        bad = 0;
        for (int i = 0; i < 50; i++) begin tick(); bad += int'(ug_on) + int'(lg_on); end
        chk("R8 mid quiet", bad, 0);

        // R9: mid to high
        pwm = 2'b01;
        wait_for(0, 1'b1, 30, n); chk("R9 de exit high", n, exp_sync() + exp_dead());
        d_ug = 1'b0;
        go_low();

        // R7: late zero-crossing, mid code 2'b11
        pwm = 2'b11;
        bad = 0;
        for (int i = 0; i < 20; i++) begin tick(); bad += int'(!lg_on); end
        chk("R7 lg holds without zc", bad, 0);
        zc = 1'b1;
        wait_for(1, 1'b0, 10, n); chk("R7 zc turn-off", n, 1);
        zc = 1'b0; d_lg = 1'b1;
        go_low();

        // R9: mid then back to low keeps lg on
        pwm = 2'b10;
        bad = 0;
        for (int i = 0; i < 8; i++) begin tick(); bad += int'(!lg_on); end
        pwm = 2'b00;
        for (int i = 0; i < 20; i++) begin tick(); bad += int'(!lg_on); end
        chk("R9 de back to low", bad, 0);

        // R10: disable and resume
        en = 1'b0; #1;
        chk("R10 en off immediate", int'(lg_on) + int'(ug_on), 0);
        d_lg = 1'b1; pwm = 2'b01;
        bad = 0;
        for (int i = 0; i < 6; i++) begin tick(); bad += int'(ug_on) + int'(lg_on); end
        chk("R10 held off", bad, 0);
        en = 1'b1;
        wait_for(0, 1'b1, 20, n); chk("R10 resume", n, exp_resume());
        pg = 1'b0; #1;
        chk("R10 pgood off immediate", int'(ug_on), 0);
        tick(); pg = 1'b1;

        // R11: power-up with mid code stays quiet
        do_reset(2'b10);
        bad = 0;
        for (int i = 0; i < 30; i++) begin tick(); bad += int'(ug_on) + int'(lg_on); end
        chk("R11 mid after reset", bad, 0);

        // Random phase: R3 and R10 invariants with a gate model
        auto_sense = 1'b1;
        do_reset(2'b00);
        h0 = pwm; h1 = pwm; h2 = pwm; lg_prev = 1'b0; ug_prev = 1'b0;
        for (int c = 0; c < 4000; c++) begin
            tick();
            h2 = h1; h1 = h0; h0 = pwm;
            chk("R3 no overlap", int'(ug_on && lg_on), 0);
            chk("R10 gated", int'(!(en && pg) && (ug_on || lg_on)), 0);
            chk("R5 ug follows high code", int'(ug_on && h2 != 2'b01), 0);
            m_lg = !lg_on && !lg_prev; lg_prev = lg_on;
            m_ug = !ug_on && !ug_prev; ug_prev = ug_on;
            if ($urandom_range(7) == 0) pwm = 2'($urandom_range(3));
            zc = ($urandom_range(3) == 0);
            en = ($urandom_range(99) != 0);
            pg = ($urandom_range(199) != 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule